// File: doc/BRIEF.md
# Table-Driven Multichannel PWM Generator

The block drives eight pulse-width-modulated outputs from a shared pattern store. It does not compare a counter against each duty value. Each word of the store holds one bit per channel. A step timer reads the words one per step in ascending order and registers them straight onto the outputs. Every step lasts the same number of clock cycles, and that includes the step where the read pointer wraps back to word zero.

Any change to a duty value means the whole pattern is regenerated. A builder state machine handles this. On a load strobe it samples the eight duty inputs, the spreading mode and the resolution mode. It then writes one word per clock into the bank that is not being played. The builder has three states:

- `BLD_IDLE`: no build is in progress.
- `BLD_FILL`: the builder is writing pattern words.
- `BLD_READY`: the new pattern is complete and waits for the period boundary.

It moves between them on these transitions:

- **start**: `BLD_IDLE` to `BLD_FILL`, on a load strobe.
- **filled**: `BLD_FILL` to `BLD_READY`, after the last word of the period has been written.
- **swap-to-idle**: `BLD_READY` to `BLD_IDLE`, at the period boundary.
- **swap-to-refill**: `BLD_READY` to `BLD_FILL`, at the period boundary, when a load arrived while busy or arrives in that same cycle.

At the swap the playback bank and the playback resolution change together. Because of this, the outputs never pause or glitch while a pattern is being rebuilt.

In contiguous mode each channel's high steps form one run at the start of the period. In spread mode a per-channel phase accumulator adds the duty value each step, modulo the period length. The channel bit is set on every carry, so the high steps are distributed evenly across the period.

Top module: `tpwm_gen`

## Requirements
- R1: Bit n of the pattern word drives `pwm_o[n]`. Every step lasts `STEP_CLKS` clock cycles, and words are played in ascending order. In contiguous mode (`spread_i` = 0 at build start), a channel with duty D is high on steps 0 to D-1 of each period and low on the rest.
- R2: Duty 0 keeps a channel low for the whole period. In full resolution, duty 255 keeps it high for 255 of the 256 steps.
- R3: In spread mode (`spread_i` = 1 at build start), step k of a period of N steps is high exactly when floor((k+1)·D/N) > floor(k·D/N). This gives D high steps per period, placed evenly.
- R4: With `half_res_i` = 1 at build start, the new pattern has a 128-step period. Any duty above 127 is treated as 127.
- R5: After the last step of the period, playback returns to step 0. The wrap step lasts exactly `STEP_CLKS` cycles, like any other step.
- R6: `busy_o` rises in the cycle after a load strobe taken in `BLD_IDLE`. The build takes one clock per word of the new period. The new pattern and resolution take effect only at the first period boundary after the build completes, and `busy_o` falls at that boundary unless a further build is queued. Until then the previous pattern keeps playing unchanged.
- R7: A load strobe that arrives while `busy_o` is high is remembered. A new build starts at the swap, using the input values present in that cycle, and `busy_o` stays high throughout.
- R8: Duty, spreading and resolution inputs are sampled only when a build starts. Changing them without a load strobe has no effect on the outputs.
- R9: After reset, `busy_o` is low, all outputs are low, and the generator plays an all-zero 256-step pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | One-cycle strobe requesting a pattern rebuild |
| duty_i | input | NCH*DW | Duty values; channel n occupies bits n*DW+DW-1 down to n*DW |
| spread_i | input | 1 | 1 selects evenly spread high steps, 0 selects one contiguous run |
| half_res_i | input | 1 | 1 selects the 128-step, 7-bit period |
| busy_o | output | 1 | High from the cycle after a taken load until the bank swap |
| pwm_o | output | NCH | Registered PWM outputs |

## Verification
The bench builds the generator with eight channels and an 8-bit duty width. With these values both the 256-step and the 128-step periods can be reached, as can the duty clamp at 127. It sets `STEP_CLKS` to 3, an odd prescale that differs from the default. This makes any error in step length or in the wrap step visible within a period of 768 clocks, so many periods, builds, queued loads and mode changes fit in a short run. A behavioural model predicts the pattern, the bank swap and `busy_o`, and its prediction is compared against the ports on every clock.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

    typedef enum logic [1:0] {
        BLD_IDLE  = 2'd0,
        BLD_FILL  = 2'd1,
        BLD_READY = 2'd2
    } bld_state_t;

endpackage

// File: rtl/tpwm_step_timer.sv
module tpwm_step_timer #(
    parameter int DW        = 8,
    parameter int STEP_CLKS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ready_i,
    input  logic          half_next_i,
    output logic [DW-1:0] ptr_o,
    output logic          bank_o,
    output logic          swap_o
);

    localparam int STEPS = 1 << DW;
    localparam int PW    = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
    localparam logic [PW-1:0] CNT_LAST  = PW'(STEP_CLKS - 1);
    localparam logic [DW-1:0] LAST_FULL = DW'(STEPS - 1);
    localparam logic [DW-1:0] LAST_HALF = DW'(STEPS / 2 - 1);

    logic [PW-1:0] cnt_q;
    logic [DW-1:0] ptr_q;
    logic          bank_q;
    logic          half_q;
    logic [DW-1:0] last_ptr;
    logic          tick;
    logic          wrap;

    always_comb begin
        last_ptr = half_q ? LAST_HALF : LAST_FULL;
        tick     = (cnt_q == CNT_LAST);
        wrap     = tick && (ptr_q == last_ptr);
        swap_o   = wrap && ready_i;
        ptr_o    = ptr_q;
        bank_o   = bank_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ptr_q  <= '0;
            bank_q <= 1'b0;
            half_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            ptr_q <= wrap ? '0 : ptr_q + 1'b1;
            if (swap_o) begin
                bank_q <= ~bank_q;
                half_q <= half_next_i;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST); // R1
    AST_PTR_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= last_ptr); // R5
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ptr_q == last_ptr) |=> (ptr_q == '0 && cnt_q == '0)); // R5

endmodule

// File: rtl/tpwm_builder.sv
module tpwm_builder
    import tpwm_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [NCH*DW-1:0] duty_i,
    input  logic              spread_i,
    input  logic              half_i,
    input  logic              swap_i,
    output logic              wr_en_o,
    output logic [DW-1:0]     wr_addr_o,
    output logic [NCH-1:0]    wr_word_o,
    output logic              ready_o,
    output logic              busy_o,
    output logic              half_snap_o
);

    localparam int STEPS = 1 << DW;
    localparam logic [DW:0]   N_FULL    = (DW + 1)'(STEPS);
    localparam logic [DW:0]   N_HALF    = (DW + 1)'(STEPS / 2);
    localparam logic [DW-1:0] MAX_HALF  = DW'(STEPS / 2 - 1);
    localparam logic [DW-1:0] LAST_FULL = DW'(STEPS - 1);

    bld_state_t    state_q;
    bld_state_t    state_n;
    logic [DW-1:0] idx_q;
    logic          pend_q;
    logic          snap_spread_q;
    logic          snap_half_q;
    logic [DW-1:0] last_idx;
    logic [DW:0]   n_per;
    logic          start;
    logic          filling;

    always_comb begin
        last_idx = snap_half_q ? MAX_HALF : LAST_FULL;
        n_per    = snap_half_q ? N_HALF : N_FULL;
        filling  = (state_q == BLD_FILL);
        start    = ((state_q == BLD_IDLE) && load_i) ||
                   (swap_i && (pend_q || load_i));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BLD_IDLE;
        else        state_q <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            BLD_IDLE:  if (load_i) state_n = BLD_FILL;
            BLD_FILL:  if (idx_q == last_idx) state_n = BLD_READY;
            BLD_READY: if (swap_i) state_n = (pend_q || load_i) ? BLD_FILL : BLD_IDLE;
            default:   state_n = BLD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o      = (state_q != BLD_IDLE);
        ready_o     = (state_q == BLD_READY);
        wr_en_o     = filling;
        wr_addr_o   = idx_q;
        half_snap_o = snap_half_q;
    end

    // shared datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q         <= '0;
            pend_q        <= 1'b0;
            snap_spread_q <= 1'b0;
            snap_half_q   <= 1'b0;
        end else begin
            if (swap_i)
                pend_q <= 1'b0;
            else if (load_i && state_q != BLD_IDLE)
                pend_q <= 1'b1;
            if (start) begin
                idx_q         <= '0;
                snap_spread_q <= spread_i;
                snap_half_q   <= half_i;
            end else if (filling) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // per-channel duty snapshot and phase accumulator
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [DW-1:0] d_in;
        logic [DW-1:0] d_clamp;
        logic [DW-1:0] d_q;
        logic [DW-1:0] acc_q;
        logic [DW:0]   sum;
        logic          carry;
        logic [DW-1:0] acc_n;

        always_comb begin
            d_in    = duty_i[ch*DW +: DW];
            d_clamp = (half_i && d_in > MAX_HALF) ? MAX_HALF : d_in;
            sum     = {1'b0, acc_q} + {1'b0, d_q};
            carry   = (sum >= n_per);
            acc_n   = carry ? DW'(sum - n_per) : sum[DW-1:0];
        end

        assign wr_word_o[ch] = snap_spread_q ? carry : (idx_q < d_q);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_q   <= '0;
                acc_q <= '0;
            end else if (start) begin
                d_q   <= d_clamp;
                acc_q <= '0;
            end else if (filling) begin
                acc_q <= acc_n;
            end
        end

        AST_ACC_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
            {1'b0, acc_q} < n_per); // R3
    end

    AST_SWAP_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        swap_i |-> (state_q == BLD_READY)); // R6
    AST_BUSY_UNTIL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !swap_i) |=> busy_o); // R6
    AST_FILL_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        filling |-> (idx_q <= last_idx)); // R4
    AST_PEND_SERVICED: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_i && pend_q) |=> (state_q == BLD_FILL && !pend_q)); // R7

endmodule

// File: rtl/tpwm_pattern_mem.sv
module tpwm_pattern_mem #(
    parameter int NCH = 8,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en_i,
    input  logic           wr_bank_i,
    input  logic [DW-1:0]  wr_addr_i,
    input  logic [NCH-1:0] wr_word_i,
    input  logic           rd_bank_i,
    input  logic [DW-1:0]  rd_addr_i,
    output logic [NCH-1:0] q_o
);

    localparam int STEPS = 1 << DW;

    logic [NCH-1:0] mem_q [2][STEPS];
    logic [NCH-1:0] q_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++)
                for (int a = 0; a < STEPS; a++)
                    mem_q[b][a] <= '0;
            q_q <= '0;
        end else begin
            if (wr_en_i)
                mem_q[wr_bank_i][wr_addr_i] <= wr_word_i;
            q_q <= mem_q[rd_bank_i][rd_addr_i];
        end
    end

    assign q_o = q_q;

    AST_NO_WRITE_TO_LIVE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (wr_bank_i != rd_bank_i)); // R6

endmodule

// File: rtl/tpwm_gen.sv
module tpwm_gen #(
    parameter int NCH       = 8,
    parameter int DW        = 8,
    parameter int STEP_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [NCH*DW-1:0] duty_i,
    input  logic              spread_i,
    input  logic              half_res_i,
    output logic              busy_o,
    output logic [NCH-1:0]    pwm_o
);

    logic           ready;
    logic           half_snap;
    logic           swap;
    logic           bank;
    logic [DW-1:0]  ptr;
    logic           wr_en;
    logic [DW-1:0]  wr_addr;
    logic [NCH-1:0] wr_word;

    tpwm_builder #(.NCH(NCH), .DW(DW)) u_builder (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .duty_i     (duty_i),
        .spread_i   (spread_i),
        .half_i     (half_res_i),
        .swap_i     (swap),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_word_o  (wr_word),
        .ready_o    (ready),
        .busy_o     (busy_o),
        .half_snap_o(half_snap)
    );

    tpwm_step_timer #(.DW(DW), .STEP_CLKS(STEP_CLKS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready_i    (ready),
        .half_next_i(half_snap),
        .ptr_o      (ptr),
        .bank_o     (bank),
        .swap_o     (swap)
    );

    tpwm_pattern_mem #(.NCH(NCH), .DW(DW)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_bank_i(~bank),
        .wr_addr_i(wr_addr),
        .wr_word_i(wr_word),
        .rd_bank_i(bank),
        .rd_addr_i(ptr),
        .q_o      (pwm_o)
    );

endmodule

// File: tb/tpwm_gen_bench.sv
module tpwm_gen_bench;

    localparam int NCH = 8;
    localparam int DW  = 8;
    localparam int SC  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            load = 1'b0;
    logic [63:0]     duty_vec = '0;
    logic            spread = 1'b0;
    logic            half = 1'b0;
    logic            busy;
    logic [NCH-1:0]  pwm;

    int    checks = 0;
    int    fails = 0;
    string tag = "R9";
    bit    done = 1'b0;

    always #2 clk = ~clk;

    tpwm_gen #(.NCH(NCH), .DW(DW), .STEP_CLKS(SC)) u_tpwm_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .duty_i    (duty_vec),
        .spread_i  (spread),
        .half_res_i(half),
        .busy_o    (busy),
        .pwm_o     (pwm)
    );

    // reference model state
    int         m_c = 0, m_ptr = 0, m_act = 0, m_h = 0, m_sh = 0;
    int         m_st = 0, m_left = 0, m_pend = 0;
    logic [7:0] m_pat [2][256];
    logic [7:0] m_out = '0;
    bit         m_busy = 1'b0;

    function automatic bit pat_bit(int k, int d, int n, bit spr);
        if (spr) return (((k + 1) * d) / n) > ((k * d) / n);
        return k < d;
    endfunction

    initial begin
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < 256; a++)
                m_pat[b][a] = '0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_c = 0; m_ptr = 0; m_act = 0; m_h = 0; m_sh = 0;
            m_st = 0; m_left = 0; m_pend = 0; m_out = '0; m_busy = 1'b0;
            for (int b = 0; b < 2; b++)
                for (int a = 0; a < 256; a++)
                    m_pat[b][a] = '0;
        end else begin
            int  old_st;
            int  last;
            bit  tick, wrp, sw, st_go;
            m_out  = m_pat[m_act][m_ptr];
            old_st = m_st;
            last   = m_h ? 127 : 255;
            tick   = (m_c == SC - 1);
            wrp    = tick && (m_ptr == last);
            sw     = wrp && (old_st == 2);
            st_go  = ((old_st == 0) && load) || (sw && (m_pend != 0 || load));
            if (sw) m_pend = 0;
            else if (load && old_st != 0) m_pend = 1;
            if (tick) begin
                m_c = 0;
                m_ptr = wrp ? 0 : m_ptr + 1;
            end else begin
                m_c++;
            end
            if (sw) begin
                m_act = 1 - m_act;
                m_h = m_sh;
            end
            if (st_go) begin
                int n;
                m_sh = half ? 1 : 0;
                n = half ? 128 : 256;
                for (int ch = 0; ch < NCH; ch++) begin
                    int d;
                    d = int'(duty_vec[ch*8 +: 8]);
                    if (half && d > 127) d = 127;
                    for (int k = 0; k < n; k++)
                        m_pat[1 - m_act][k][ch] = pat_bit(k, d, n, spread);
                end
                m_st = 1;
                m_left = n;
            end else if (sw) begin
                m_st = 0;
            end else if (old_st == 1) begin
                m_left--;
                if (m_left == 0) m_st = 2;
            end
            m_busy = (m_st != 0);
        end
    end

    // per-clock comparison at the ports
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (pwm !== m_out || busy !== m_busy) begin
                fails++;
                $display("FAIL %s: pwm=%h busy=%b expected pwm=%h busy=%b at %0t",
                         tag, pwm, busy, m_out, m_busy, $time);
            end
        end
    end

    task automatic set_duties(input int d0, d1, d2, d3, d4, d5, d6, d7);
        @(negedge clk);
        duty_vec = {8'(d7), 8'(d6), 8'(d5), 8'(d4), 8'(d3), 8'(d2), 8'(d1), 8'(d0)};
    endtask

    task automatic pulse_load();
        @(negedge clk);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic run_periods(input int p);
        repeat (p * 256 * SC) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        tag = "R9";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_periods(1);

        // R1: contiguous mode, mixed duties
        tag = "R1";
        set_duties(1, 17, 64, 100, 128, 3, 200, 90);
        spread = 1'b0; half = 1'b0;
        pulse_load();
        tag = "R6";
        wait_idle();
        tag = "R1";
        run_periods(2);

        // R2: extreme duties
        tag = "R2";
        set_duties(0, 255, 0, 255, 254, 1, 0, 255);
        pulse_load();
        wait_idle();
        tag = "R5";
        run_periods(2);

        // R3: spread mode
        tag = "R3";
        set_duties(1, 3, 85, 128, 129, 200, 255, 0);
        spread = 1'b1;
        pulse_load();
        wait_idle();
        run_periods(2);

        // R4: half resolution with clamping
        tag = "R4";
        set_duties(200, 127, 0, 64, 128, 5, 255, 100);
        half = 1'b1; spread = 1'b0;
        pulse_load();
        wait_idle();
        run_periods(2);
        spread = 1'b1;
        pulse_load();
        wait_idle();
        run_periods(1);

        // R7: load while busy, new inputs taken at the swap
        tag = "R7";
        set_duties(10, 20, 30, 40, 50, 60, 70, 80);
        half = 1'b0; spread = 1'b0;
        pulse_load();
        repeat (20) @(negedge clk);
        set_duties(250, 5, 120, 33, 0, 77, 160, 2);
        spread = 1'b1;
        pulse_load();
        wait_idle();
        run_periods(2);

        // R8: inputs changed without a load have no effect
        tag = "R8";
        set_duties(99, 99, 99, 99, 99, 99, 99, 99);
        spread = 1'b0; half = 1'b1;
        run_periods(2);

        // R6: load issued late in a period, back to full resolution
        tag = "R6";
        half = 1'b0;
        repeat (200 * SC) @(negedge clk);
        pulse_load();
        wait_idle();
        run_periods(1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule